// File: doc/BRIEF.md
# Root Hub Port Status Controller

This block keeps the status word of one downstream port of a USB host root hub. The low half of the 32-bit word carries live status: connection, enable, suspend, overcurrent, reset in progress, power and low-speed device. The high half carries sticky change flags. Hardware events set these flags, and the host driver clears each one by writing a 1 to it.

The same register port also takes driver commands. Writing a 1 to selected low-half bit positions starts an action: a port reset, a suspend, a resume, an enable change or a power change. Two internal millisecond timers, stepped by a one-cycle tick input, time the port reset pulse and the three-phase resume sequence. The change flags that report the end of those sequences are raised when the timers finish. The timer lengths are parameters.

Hardware inputs give the debounced connect level, the low-speed indication, the port overcurrent level and a one-cycle request to disable the port in hardware. The block drives three line-control outputs that mark the reset pulse, the resume pulse and the end-of-packet phase of a resume.

Top module: `rh_port_status`

## Requirements
- R1: After reset every defined status bit and change flag reads 0. Reserved positions (31:21, 15:10, 7:5) always read 0.
- R2: The read word places connect-change at 16, enable-change at 17, suspend-change at 18, overcurrent-change at 19 and reset-change at 20. It places connected at 0, enabled at 1, suspended at 2, overcurrent at 3, reset-active at 4, powered at 8 and low-speed at 9.
- R3: Writing 1 to a change flag position clears that flag. Writing 0 leaves it unchanged.
- R4: Connected follows conn_i one cycle later, and connect-change sets on every edge of conn_i. Low-speed reads conn_i AND low_speed_i, registered.
- R5: Writing 1 to bit 4 sets reset-active and reset_sig_o. After RESET_MS ticks counted from the cycle after the write, reset-active clears, reset-change sets, and enabled takes the value of the connect input. A reset with nothing connected leaves the port disabled.
- R6: Writing 1 to bit 2 while enabled sets suspended. Writing 1 to bit 3 while suspended runs a resume: resume_sig_o for RESUME_MS ticks, then eop_sig_o for EOP_MS ticks, then RESYNC_MS silent ticks. Only then does suspended clear and suspend-change set.
- R7: Whenever reset-change becomes set, suspend-change is forced to 0.
- R8: Enable-change sets when hardware clears enabled: through hw_disable_i, a disconnect, or overcurrent in per-port mode. A driver enable (bit 1) or a driver disable (bit 0) never sets it.
- R9: With PER_PORT_OC=1 the overcurrent bit follows ovc_i, and overcurrent-change sets on each of its changes. With PER_PORT_OC=0 both bits stay 0.
- R10: Writing 1 to bit 8 sets powered. Writing 1 to bit 9 clears powered and disables the port without setting enable-change.
- R11: When a change flag's set event and a driver write-1 clear of that flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data: clear mask for change flags and command bits |
| rd_data_o | output | 32 | Port status word |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| conn_i | input | 1 | Debounced device-connected level |
| low_speed_i | input | 1 | Attached device is low speed |
| ovc_i | input | 1 | Port overcurrent level |
| hw_disable_i | input | 1 | Hardware request to disable the port |
| reset_sig_o | output | 1 | Port reset signalling active |
| resume_sig_o | output | 1 | Resume pulse active |
| eop_sig_o | output | 1 | End-of-packet phase of resume active |

## Verification
The bench builds the main instance with RESET_MS=4, RESUME_MS=5, EOP_MS=1 and RESYNC_MS=2. With these lengths, complete reset and resume sequences finish in a few ticks, so tick-exact boundary checks stay short. Per-port overcurrent is enabled, which brings the overcurrent-change flag and overcurrent-caused disables within reach. A second instance with PER_PORT_OC=0 shares the stimulus to show that the overcurrent bits stay 0 in that mode.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  // status bit positions (low half)
  localparam int unsigned ST_CCS  = 0;
  localparam int unsigned ST_PES  = 1;
  localparam int unsigned ST_PSS  = 2;
  localparam int unsigned ST_POCI = 3;
  localparam int unsigned ST_PRS  = 4;
  localparam int unsigned ST_PPS  = 8;
  localparam int unsigned ST_LSDA = 9;

  // command bit positions in write data
  localparam int unsigned CMD_EN_CLR  = 0;
  localparam int unsigned CMD_EN_SET  = 1;
  localparam int unsigned CMD_SUSPEND = 2;
  localparam int unsigned CMD_RESUME  = 3;
  localparam int unsigned CMD_RESET   = 4;
  localparam int unsigned CMD_PWR_ON  = 8;
  localparam int unsigned CMD_PWR_OFF = 9;

  // change flags: index i lives at bit CHG_LSB + i
  localparam int unsigned CHG_LSB = 16;
  localparam int unsigned CHG_N   = 5;
  localparam int unsigned CH_CONN = 0;
  localparam int unsigned CH_EN   = 1;
  localparam int unsigned CH_SUSP = 2;
  localparam int unsigned CH_OC   = 3;
  localparam int unsigned CH_RST  = 4;

  typedef enum logic [1:0] {
    RSM_IDLE   = 2'd0,
    RSM_PULSE  = 2'd1,
    RSM_EOP    = 2'd2,
    RSM_RESYNC = 2'd3
  } rsm_phase_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rh_ms_timer.sv
module rh_ms_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && tick_i && (cnt_q == len_i - CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (done_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rh_reset_seq.sv
module rh_reset_seq #(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned RESET_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LEN = CNT_W'(RESET_MS);

  rh_ms_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i && !busy_o),
    .abort_i (1'b0),
    .len_i   (LEN),
    .tick_i  (tick_i),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/rh_resume_seq.sv
module rh_resume_seq
  import rh_port_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned RESUME_MS = 20,
  parameter int unsigned EOP_MS    = 1,
  parameter int unsigned RESYNC_MS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic tick_i,
  output logic busy_o,
  output logic pulse_o,
  output logic eop_o,
  output logic done_o
);
  rsm_phase_e       phase_q;
  logic [CNT_W-1:0] len;
  logic             tmr_start, tmr_done, tmr_busy, go;

  assign go = start_i && (phase_q == RSM_IDLE);

  always_comb begin
    unique case (phase_q)
      RSM_EOP:    len = CNT_W'(EOP_MS);
      RSM_RESYNC: len = CNT_W'(RESYNC_MS);
      default:    len = CNT_W'(RESUME_MS);
    endcase
  end

  assign tmr_start = go || (tmr_done && phase_q != RSM_RESYNC);

  rh_ms_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .abort_i (abort_i),
    .len_i   (len),
    .tick_i  (tick_i),
    .busy_o  (tmr_busy),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= RSM_IDLE;
    end else if (abort_i) begin
      phase_q <= RSM_IDLE;
    end else if (go) begin
      phase_q <= RSM_PULSE;
    end else if (tmr_done) begin
      unique case (phase_q)
        RSM_PULSE: phase_q <= RSM_EOP;
        RSM_EOP:   phase_q <= RSM_RESYNC;
        default:   phase_q <= RSM_IDLE;
      endcase
    end
  end

  assign busy_o  = (phase_q != RSM_IDLE);
  assign pulse_o = (phase_q == RSM_PULSE);
  assign eop_o   = (phase_q == RSM_EOP);
  assign done_o  = tmr_done && (phase_q == RSM_RESYNC) && !abort_i;

  logic unused_busy;
  assign unused_busy = tmr_busy;
endmodule

// File: rtl/rh_change_reg.sv
module rh_change_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] kill_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (kill_i[i]) q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;   // set beats driver clear
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
  import rh_port_pkg::*;
#(
  parameter int unsigned RESET_MS    = 10,
  parameter int unsigned RESUME_MS   = 20,
  parameter int unsigned EOP_MS      = 1,
  parameter int unsigned RESYNC_MS   = 3,
  parameter bit          PER_PORT_OC = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        ms_tick_i,
  input  logic        conn_i,
  input  logic        low_speed_i,
  input  logic        ovc_i,
  input  logic        hw_disable_i,
  output logic        reset_sig_o,
  output logic        resume_sig_o,
  output logic        eop_sig_o
);
  localparam int unsigned MAX_MS = max3(RESET_MS, RESUME_MS, max3(EOP_MS, RESYNC_MS, 1));
  localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

  logic ccs_q, lsda_q, poci_q, pes_q, pss_q, pps_q;
  logic pes_d, pss_d, pps_d;

  logic [CHG_N-1:0] chg_q, chg_set, chg_clr, chg_kill;

  logic cmd_en_clr, cmd_en_set, cmd_suspend, cmd_resume, cmd_reset, cmd_pwr_on, cmd_pwr_off;
  logic rst_busy, rst_done, rst_start;
  logic rsm_busy, rsm_pulse, rsm_eop, rsm_done, rsm_start, rsm_abort;
  logic hw_clr, oc_hit;

  assign cmd_en_clr  = wr_en_i && wr_data_i[CMD_EN_CLR];
  assign cmd_en_set  = wr_en_i && wr_data_i[CMD_EN_SET];
  assign cmd_suspend = wr_en_i && wr_data_i[CMD_SUSPEND];
  assign cmd_resume  = wr_en_i && wr_data_i[CMD_RESUME];
  assign cmd_reset   = wr_en_i && wr_data_i[CMD_RESET];
  assign cmd_pwr_on  = wr_en_i && wr_data_i[CMD_PWR_ON];
  assign cmd_pwr_off = wr_en_i && wr_data_i[CMD_PWR_OFF];

  // reset pulse timer
  assign rst_start = cmd_reset && !rst_busy;

  rh_reset_seq #(.CNT_W(MS_W), .RESET_MS(RESET_MS)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rst_start),
    .tick_i  (ms_tick_i),
    .busy_o  (rst_busy),
    .done_o  (rst_done)
  );

  // resume sequence
  assign rsm_start = cmd_resume && pss_q && !rst_busy;
  assign rsm_abort = rst_start || !pes_d;

  rh_resume_seq #(
    .CNT_W(MS_W), .RESUME_MS(RESUME_MS), .EOP_MS(EOP_MS), .RESYNC_MS(RESYNC_MS)
  ) u_rsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rsm_start),
    .abort_i (rsm_abort),
    .tick_i  (ms_tick_i),
    .busy_o  (rsm_busy),
    .pulse_o (rsm_pulse),
    .eop_o   (rsm_eop),
    .done_o  (rsm_done)
  );

  // hardware-caused disable sources
  assign oc_hit = PER_PORT_OC && ovc_i;
  assign hw_clr = !conn_i || hw_disable_i || oc_hit;

  always_comb begin
    pps_d = pps_q;
    if (cmd_pwr_on)  pps_d = 1'b1;
    if (cmd_pwr_off) pps_d = 1'b0;

    pes_d = pes_q;
    if (cmd_en_set && ccs_q) pes_d = 1'b1;
    if (cmd_en_clr)          pes_d = 1'b0;
    if (cmd_pwr_off)         pes_d = 1'b0;
    if (rst_done)            pes_d = conn_i;
    if (hw_clr)              pes_d = 1'b0;

    pss_d = pss_q;
    if (cmd_suspend && pes_q && !rst_busy) pss_d = 1'b1;
    if (rsm_done || rst_start || !pes_d)    pss_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_q  <= 1'b0;
      lsda_q <= 1'b0;
      poci_q <= 1'b0;
      pes_q  <= 1'b0;
      pss_q  <= 1'b0;
      pps_q  <= 1'b0;
    end else begin
      ccs_q  <= conn_i;
      lsda_q <= conn_i && low_speed_i;
      poci_q <= PER_PORT_OC && ovc_i;
      pes_q  <= pes_d;
      pss_q  <= pss_d;
      pps_q  <= pps_d;
    end
  end

  // change flags
  always_comb begin
    chg_set          = '0;
    chg_set[CH_CONN] = (conn_i != ccs_q);
    chg_set[CH_EN]   = pes_q && hw_clr;
    chg_set[CH_SUSP] = rsm_done && !rst_done;
    chg_set[CH_OC]   = PER_PORT_OC && (ovc_i != poci_q);
    chg_set[CH_RST]  = rst_done;

    chg_kill          = '0;
    chg_kill[CH_SUSP] = rst_done;

    chg_clr = wr_en_i ? wr_data_i[CHG_LSB +: CHG_N] : '0;
  end

  rh_change_reg #(.N(CHG_N)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chg_set),
    .clr_i  (chg_clr),
    .kill_i (chg_kill),
    .q_o    (chg_q)
  );

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[CHG_LSB +: CHG_N]     = chg_q;
    rd_data_o[ST_CCS]               = ccs_q;
    rd_data_o[ST_PES]               = pes_q;
    rd_data_o[ST_PSS]               = pss_q;
    rd_data_o[ST_POCI]              = poci_q;
    rd_data_o[ST_PRS]               = rst_busy;
    rd_data_o[ST_PPS]               = pps_q;
    rd_data_o[ST_LSDA]              = lsda_q;
  end

  assign reset_sig_o  = rst_busy;
  assign resume_sig_o = rsm_pulse;
  assign eop_sig_o    = rsm_eop;

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[31:21], wr_data_i[15:10], wr_data_i[7:5], rsm_busy};
endmodule

// File: rtl/rh_port_status_chk.sv
module rh_port_status_chk #(
  parameter bit PER_PORT_OC = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        reset_sig_o,
  input logic        resume_sig_o,
  input logic        eop_sig_o
);
  AST_CSC_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[16]) |-> $past(wr_en_i && wr_data_i[16])); // R3

  AST_RST_END_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[4]) |-> rd_data_o[20]); // R5

  AST_RST_END_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[4]) |-> (!rd_data_o[1] || rd_data_o[0])); // R5

  AST_PSSC_ON_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[18]) |-> ($past(rd_data_o[2]) && !rd_data_o[2])); // R6

  AST_LINE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_sig_o, resume_sig_o, eop_sig_o})); // R6

  AST_PRSC_KILLS_PSSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[20]) |-> !rd_data_o[18]); // R7

  AST_PESC_HW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[17]) |-> ($past(rd_data_o[1]) && !rd_data_o[1])); // R8

  AST_OC_GLOBAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !PER_PORT_OC |-> (!rd_data_o[19] && !rd_data_o[3])); // R9
endmodule

bind rh_port_status rh_port_status_chk #(.PER_PORT_OC(PER_PORT_OC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .reset_sig_o  (reset_sig_o),
  .resume_sig_o (resume_sig_o),
  .eop_sig_o    (eop_sig_o)
);

// File: tb/rh_port_status_test.sv
module rh_port_status_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        ms_tick_i = 1'b0;
  logic        conn_i = 1'b0;
  logic        low_speed_i = 1'b0;
  logic        ovc_i = 1'b0;
  logic        hw_disable_i = 1'b0;
  logic [31:0] rd_data_o, rd_gl;
  logic        reset_sig_o, resume_sig_o, eop_sig_o;
  logic        rs_gl, rm_gl, eo_gl;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  rh_port_status #(.RESET_MS(4), .RESUME_MS(5), .EOP_MS(1), .RESYNC_MS(2), .PER_PORT_OC(1'b1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .ms_tick_i(ms_tick_i), .conn_i(conn_i),
    .low_speed_i(low_speed_i), .ovc_i(ovc_i), .hw_disable_i(hw_disable_i),
    .reset_sig_o(reset_sig_o), .resume_sig_o(resume_sig_o), .eop_sig_o(eop_sig_o));

  rh_port_status #(.RESET_MS(4), .RESUME_MS(5), .EOP_MS(1), .RESYNC_MS(2), .PER_PORT_OC(1'b0)) uut_gl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_gl), .ms_tick_i(ms_tick_i), .conn_i(conn_i),
    .low_speed_i(low_speed_i), .ovc_i(ovc_i), .hw_disable_i(hw_disable_i),
    .reset_sig_o(rs_gl), .resume_sig_o(rm_gl), .eop_sig_o(eo_gl));

  // {conn, low, ovc, hw_dis, wr_en, wr_data, expected rd}
  localparam int NV = 15;
  localparam logic [68:0] VEC [NV] = '{
    {5'b10000, 32'h0000_0000, 32'h0001_0001},  // R4 connect
    {5'b11001, 32'h0001_0000, 32'h0000_0201},  // R3 clear csc, R4 low speed
    {5'b11001, 32'h0000_0100, 32'h0000_0301},  // R10 power on
    {5'b11001, 32'h0000_0002, 32'h0000_0303},  // R8 driver enable
    {5'b11001, 32'h0000_0001, 32'h0000_0301},  // R8 driver disable, no flag
    {5'b11001, 32'h0000_0002, 32'h0000_0303},
    {5'b11010, 32'h0000_0000, 32'h0002_0301},  // R8 hw disable
    {5'b11001, 32'h0000_0000, 32'h0002_0301},  // R3 write 0 no effect
    {5'b11001, 32'h0002_0000, 32'h0000_0301},  // R3
    {5'b11001, 32'h0000_0002, 32'h0000_0303},
    {5'b11100, 32'h0000_0000, 32'h000A_0309},  // R9 overcurrent, R8
    {5'b11001, 32'h000A_0000, 32'h0008_0301},  // R11 set beats clear
    {5'b11001, 32'h0008_0000, 32'h0000_0301},
    {5'b00000, 32'h0000_0000, 32'h0001_0100},  // R4 disconnect
    {5'b00001, 32'h0001_0000, 32'h0000_0100}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      ms_tick_i = 1'b1;
      @(negedge clk_i);
      ms_tick_i = 1'b0;
    end
  endtask

  task automatic set_conn(input logic c);
    @(negedge clk_i);
    conn_i = c;
    @(negedge clk_i);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset word", rd_data_o, 32'h0);
    check("R1 line outputs", {29'd0, reset_sig_o, resume_sig_o, eop_sig_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after release", rd_data_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {conn_i, low_speed_i, ovc_i, hw_disable_i, wr_en_i} = VEC[i][68:64];
      wr_data_i = VEC[i][63:32];
      @(negedge clk_i);
      check($sformatf("R2 vector %0d", i), rd_data_o, VEC[i][31:0]);
      if (i == 10) check("R9 global mode oc bits", {28'd0, rd_gl[19], rd_gl[3], 2'b0}, 32'h0);
      wr_en_i = 1'b0;
      wr_data_i = '0;
      hw_disable_i = 1'b0;
    end
    low_speed_i = 1'b0;

    // R5 reset with a device connected
    set_conn(1'b1);
    wr(32'h0001_0000);
    wr(32'h0000_0100);
    ticks(2);  // idle ticks must not count
    wr(32'h0000_0010);
    check("R5 reset active", {rd_data_o[31:1], reset_sig_o}, {32'h0000_0111 >> 1, 1'b1});
    ticks(3);
    check("R5 still in reset", rd_data_o, 32'h0000_0111);
    ticks(1);
    check("R5 reset done enables", rd_data_o, 32'h0010_0103);
    wr(32'h0010_0000);

    // R6 suspend and resume
    wr(32'h0000_0004);
    check("R6 suspended", rd_data_o, 32'h0000_0107);
    wr(32'h0000_0008);
    check("R6 resume pulse", {29'd0, reset_sig_o, resume_sig_o, eop_sig_o}, 32'h2);
    ticks(5);
    check("R6 eop phase", {29'd0, reset_sig_o, resume_sig_o, eop_sig_o}, 32'h1);
    ticks(1);
    check("R6 resync still suspended", rd_data_o, 32'h0000_0107);
    ticks(1);
    check("R6 one tick before end", rd_data_o, 32'h0000_0107);
    ticks(1);
    check("R6 resume complete", rd_data_o, 32'h0004_0103);

    // R7 reset completion wipes suspend-change
    wr(32'h0000_0010);
    check("R7 pssc held during reset", rd_data_o[18], 1'b1);
    ticks(4);
    check("R7 prsc set pssc cleared", rd_data_o, 32'h0010_0103);
    wr(32'h0010_0000);

    // R5 reset with nothing connected
    set_conn(1'b0);
    check("R8 disconnect disables", rd_data_o, 32'h0003_0100);
    wr(32'h0003_0000);
    wr(32'h0000_0010);
    ticks(4);
    check("R5 reset unconnected stays disabled", rd_data_o, 32'h0010_0100);
    wr(32'h0010_0000);

    // R10 power off disables without enable-change
    set_conn(1'b1);
    wr(32'h0001_0000);
    wr(32'h0000_0002);
    check("R10 enabled", rd_data_o, 32'h0000_0103);
    wr(32'h0000_0200);
    check("R10 power off no pesc", rd_data_o, 32'h0000_0001);

    summary();
  end
endmodule